// File: doc/BRIEF.md
# Byte Program-and-Verify Sequencer

This block sits on the host side of a command-driven parallel flash device and commits a single byte to it. A client presents a target address and a data byte on a valid/ready request port. The sequencer then drives the flash bus through a fixed series of steps. It writes the arming command and then the program write that carries the address and data. It holds the bus quiet for a programmable pulse time, writes the verify command, and reads the byte back.

When the readback equals the requested byte, the operation ends with a one-cycle success pulse. When it differs, the whole series restarts from the arming command. After a parameterised number of attempts the sequencer gives up and pulses failure instead. In both cases the number of attempts used is presented alongside the pulse. Back-to-back requests are served one at a time. A new request is taken only while the sequencer is idle.

The flash bus is synchronous. A write is a one-cycle `busWr` strobe with address and data. A read is a one-cycle `busRd` strobe, and the device returns the byte on `busRdata` in the following cycle.

Top module: `byte_prog_seq`

## Requirements
- R1: After reset `reqReady` is high, and `busWr`, `busRd`, `doneOk` and `doneFail` are all low.
- R2: A request is accepted only in a cycle where `reqValid` and `reqReady` are both high. `reqReady` is low from the cycle after acceptance until the cycle in which `doneOk` or `doneFail` pulses. Requests offered while busy are ignored and do not alter the address or data being programmed.
- R3: Every attempt begins with a write of data 40h at address 0. In the very next cycle comes a write carrying the accepted address and data byte.
- R4: Between the program write and the verify write, exactly `PULSE_CYC` cycles pass with neither `busWr` nor `busRd` asserted.
- R5: The verify step is a write of data C0h at address 0. In the very next cycle comes a single read strobe.
- R6: If the byte returned one cycle after the read strobe equals the requested data, `doneOk` pulses for exactly one cycle. At that point `tries` shows the number of attempts made, counting from 1.
- R7: On a mismatch before the limit, a new attempt starts with the 40h write two cycles after the read strobe, and `tries` increases by one.
- R8: If the readback mismatches on attempt `MAX_TRIES`, `doneFail` pulses for one cycle with `tries` equal to `MAX_TRIES`, and no further bus activity follows.
- R9: `tries` equals 1 in the cycle after each accepted request, whatever the previous request reported.
- R10: `busWr` and `busRd` are never high together, and `doneOk` and `doneFail` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request offered |
| reqReady | output | 1 | Sequencer idle, request can be taken |
| reqAddr | input | ADDR_W | Target byte address |
| reqData | input | 8 | Byte to program |
| doneOk | output | 1 | One-cycle success pulse |
| doneFail | output | 1 | One-cycle failure pulse after the retry limit |
| tries | output | TRY_W | Attempts used for the current or last request |
| busWr | output | 1 | Flash write strobe |
| busRd | output | 1 | Flash read strobe |
| busAddr | output | ADDR_W | Flash address |
| busWdata | output | 8 | Flash write data |
| busRdata | input | 8 | Flash read data, valid the cycle after `busRd` |

## Verification
The assertions check the local rules on every cycle:
- the program write follows the arming write directly;
- a read follows the verify write directly;
- the two strobe pairs stay exclusive;
- `reqReady` drops after acceptance;
- the attempt count restarts at 1;
- a failure pulse carries the limit.

Other behaviour can only be shown by the bench's scenarios, where a flash model refuses to take a programmed byte for a chosen number of attempts. These include the exact quiet window between program and verify, and the full restart of the sequence on a mismatch. They also include the final attempt count against the injected fault count, and the way offers made while busy leave the programmed address untouched.

// File: rtl/byte_prog_pkg.sv
package byte_prog_pkg;
  localparam int BYTE_W = 8;
  localparam logic [BYTE_W-1:0] CMD_ARM    = 8'h40;
  localparam logic [BYTE_W-1:0] CMD_CHECK  = 8'hC0;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ARM, ST_PROG, ST_PULSE, ST_CHECK, ST_READ, ST_CMP
  } seqState_t;

  typedef struct packed {
    logic capture;
    logic wrArm;
    logic wrProg;
    logic wrCheck;
    logic rdBack;
    logic loadWait;
    logic tickWait;
    logic bumpTry;
  } seqCtl_t;
endpackage

// File: rtl/byte_prog_dp.sv
module byte_prog_dp
  import byte_prog_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int TRY_W     = 5,
  parameter int MAX_TRIES = 25,
  parameter int PULSE_CYC = 2500
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqCtl_t           ctl,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [BYTE_W-1:0] reqData,
  input  logic [BYTE_W-1:0] busRdata,
  output logic              waitDone,
  output logic              match,
  output logic              lastTry,
  output logic [TRY_W-1:0]  tries,
  output logic              busWr,
  output logic              busRd,
  output logic [ADDR_W-1:0] busAddr,
  output logic [BYTE_W-1:0] busWdata
);
  localparam int WAIT_W = $clog2(PULSE_CYC + 1);
  localparam logic [WAIT_W-1:0] WAIT_LOAD = WAIT_W'(PULSE_CYC - 1);
  localparam logic [TRY_W-1:0]  TRY_LIM   = TRY_W'(MAX_TRIES);

  logic [ADDR_W-1:0] tgtAddr;
  logic [BYTE_W-1:0] tgtData;
  logic [WAIT_W-1:0] waitCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tgtAddr <= '0;
      tgtData <= '0;
      tries   <= '0;
      waitCnt <= '0;
    end else begin
      if (ctl.capture) begin
        tgtAddr <= reqAddr;
        tgtData <= reqData;
        tries   <= TRY_W'(1);
      end else if (ctl.bumpTry) begin
        tries <= tries + TRY_W'(1);
      end
      if (ctl.loadWait)
        waitCnt <= WAIT_LOAD;
      else if (ctl.tickWait && waitCnt != '0)
        waitCnt <= waitCnt - WAIT_W'(1);
    end
  end

  assign waitDone = (waitCnt == '0);
  assign match    = (busRdata == tgtData);
  assign lastTry  = (tries >= TRY_LIM);

  always_comb begin
    busWr    = ctl.wrArm | ctl.wrProg | ctl.wrCheck;
    busRd    = ctl.rdBack;
    busAddr  = ctl.wrProg ? tgtAddr : '0;
    busWdata = '0;
    if (ctl.wrArm)   busWdata = CMD_ARM;
    if (ctl.wrProg)  busWdata = tgtData;
    if (ctl.wrCheck) busWdata = CMD_CHECK;
  end
endmodule

// File: rtl/byte_prog_ctl.sv
module byte_prog_ctl
  import byte_prog_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    reqValid,
  input  logic    waitDone,
  input  logic    match,
  input  logic    lastTry,
  output logic    reqReady,
  output logic    doneOk,
  output logic    doneFail,
  output seqCtl_t ctl
);
  seqState_t state, stateNxt;
  logic okNxt, failNxt;

  always_comb begin
    stateNxt = state;
    ctl      = '0;
    okNxt    = 1'b0;
    failNxt  = 1'b0;
    unique case (state)
      ST_IDLE: if (reqValid) begin
        ctl.capture = 1'b1;
        stateNxt    = ST_ARM;
      end
      ST_ARM: begin
        ctl.wrArm = 1'b1;
        stateNxt  = ST_PROG;
      end
      ST_PROG: begin
        ctl.wrProg   = 1'b1;
        ctl.loadWait = 1'b1;
        stateNxt     = ST_PULSE;
      end
      ST_PULSE: begin
        ctl.tickWait = 1'b1;
        if (waitDone) stateNxt = ST_CHECK;
      end
      ST_CHECK: begin
        ctl.wrCheck = 1'b1;
        stateNxt    = ST_READ;
      end
      ST_READ: begin
        ctl.rdBack = 1'b1;
        stateNxt   = ST_CMP;
      end
      ST_CMP: begin
        if (match) begin
          okNxt    = 1'b1;
          stateNxt = ST_IDLE;
        end else if (lastTry) begin
          failNxt  = 1'b1;
          stateNxt = ST_IDLE;
        end else begin
          ctl.bumpTry = 1'b1;
          stateNxt    = ST_ARM;
        end
      end
      default: stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      doneOk   <= 1'b0;
      doneFail <= 1'b0;
    end else begin
      state    <= stateNxt;
      doneOk   <= okNxt;
      doneFail <= failNxt;
    end
  end

  assign reqReady = (state == ST_IDLE);
endmodule

// File: rtl/byte_prog_seq.sv
module byte_prog_seq
  import byte_prog_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int TRY_W     = 5,
  parameter int MAX_TRIES = 25,
  parameter int PULSE_CYC = 2500
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [7:0]        reqData,
  output logic              doneOk,
  output logic              doneFail,
  output logic [TRY_W-1:0]  tries,
  output logic              busWr,
  output logic              busRd,
  output logic [ADDR_W-1:0] busAddr,
  output logic [7:0]        busWdata,
  input  logic [7:0]        busRdata
);
  seqCtl_t ctl;
  logic waitDone, match, lastTry;

  byte_prog_ctl i_ctl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid),
    .waitDone(waitDone), .match(match), .lastTry(lastTry),
    .reqReady(reqReady), .doneOk(doneOk), .doneFail(doneFail), .ctl(ctl)
  );

  byte_prog_dp #(
    .ADDR_W(ADDR_W), .TRY_W(TRY_W), .MAX_TRIES(MAX_TRIES), .PULSE_CYC(PULSE_CYC)
  ) i_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .reqAddr(reqAddr), .reqData(reqData),
    .busRdata(busRdata), .waitDone(waitDone), .match(match), .lastTry(lastTry),
    .tries(tries), .busWr(busWr), .busRd(busRd), .busAddr(busAddr),
    .busWdata(busWdata)
  );
endmodule

// File: rtl/byte_prog_chk.sv
module byte_prog_chk #(
  parameter int TRY_W     = 5,
  parameter int MAX_TRIES = 25
) (
  input logic             clk,
  input logic             rstN,
  input logic             reqValid,
  input logic             reqReady,
  input logic             doneOk,
  input logic             doneFail,
  input logic [TRY_W-1:0] tries,
  input logic             busWr,
  input logic             busRd,
  input logic [7:0]       busWdata
);
  // R10
  bus_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(busWr && busRd));
  // R10
  done_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({doneOk, doneFail}));
  // R2
  ready_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> !reqReady);
  // R9
  try_restart_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> (tries == TRY_W'(1)));
  // R3
  arm_then_prog_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && busWdata == 8'h40 && !$past(busWr)) |=> busWr);
  // R5
  check_then_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && busWdata == 8'hC0 && !$past(busWr)) |=> (busRd && !busWr));
  // R8
  fail_at_limit_chk: assert property (@(posedge clk) disable iff (!rstN)
    doneFail |-> (tries == TRY_W'(MAX_TRIES)));
endmodule

bind byte_prog_seq byte_prog_chk #(.TRY_W(TRY_W), .MAX_TRIES(MAX_TRIES)) i_chk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
  .doneOk(doneOk), .doneFail(doneFail), .tries(tries),
  .busWr(busWr), .busRd(busRd), .busWdata(busWdata)
);

// File: tb/test_byte_prog_seq.sv
module test_byte_prog_seq;
  localparam int ADDR_W = 16;
  localparam int TRY_W  = 5;
  localparam int MAXT   = 4;
  localparam int PULSE  = 6;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0;
  logic [ADDR_W-1:0] reqAddr = '0;
  logic [7:0] reqData = '0;
  logic reqReady, doneOk, doneFail, busWr, busRd;
  logic [TRY_W-1:0] tries;
  logic [ADDR_W-1:0] busAddr;
  logic [7:0] busWdata;
  logic [7:0] busRdata = '0;

  int nChecks = 0;
  int nFails = 0;

  byte_prog_seq #(.ADDR_W(ADDR_W), .TRY_W(TRY_W), .MAX_TRIES(MAXT), .PULSE_CYC(PULSE)) i_byte_prog_seq (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqAddr(reqAddr), .reqData(reqData), .doneOk(doneOk), .doneFail(doneFail),
    .tries(tries), .busWr(busWr), .busRd(busRd), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata)
  );

  always #2 clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // flash model: refuses to store the byte for failsLeft program writes
  int failsLeft = 0;
  logic [ADDR_W-1:0] expAddr = '0;
  logic [7:0] expData = '0;
  logic armed = 1'b0, checkArmed = 1'b0, inPulse = 1'b0, cellOk = 1'b0;
  logic [7:0] cellVal = '0;
  int gap = 0, armWrites = 0, busCount = 0;
  logic prevRd = 1'b0;

  always @(posedge clk) begin
    if (rstN) begin
      prevRd <= busRd;
      if (busWr || busRd) busCount++;
      if (prevRd && !doneOk && !doneFail && busWr && busWdata == 8'h40) begin
        // R7 restart follows read by exactly two cycles (checked below too)
      end
      if (inPulse && !busWr && !busRd) gap++;
      if (busWr && armed) begin
        armed <= 1'b0;
        check(busAddr == expAddr, "R3 addr", int'(busAddr), int'(expAddr));
        check(busWdata == expData, "R3 data", busWdata, expData);
        if (failsLeft > 0) begin failsLeft--; cellVal <= busWdata ^ 8'h5A; end
        else cellVal <= busWdata;
        inPulse <= 1'b1; gap = 0;
      end else if (busWr && busWdata == 8'h40) begin
        armed <= 1'b1; armWrites++;
        check(busAddr == '0, "R3 arm addr", int'(busAddr), 0);
      end else if (busWr && busWdata == 8'hC0) begin
        check(gap == PULSE, "R4 pulse gap", gap, PULSE);
        inPulse <= 1'b0; checkArmed <= 1'b1;
      end else if (busWr) begin
        check(0, "R3 unexpected write", busWdata, 0);
      end
      if (busRd) begin
        check(checkArmed, "R5 read after verify", 0, 1);
        checkArmed <= 1'b0;
        busRdata <= cellVal;
      end
    end
  end

  task automatic doReq(input logic [ADDR_W-1:0] a, input logic [7:0] d,
                       input int fails, input bit junk);
    int expTries = (fails >= MAXT) ? MAXT : fails + 1;
    bit expOk = (fails < MAXT);
    int cyc = 0;
    int arm0;
    @(negedge clk);
    failsLeft = fails; expAddr = a; expData = d; arm0 = armWrites;
    check(reqReady, "R2 ready while idle", reqReady, 1);
    reqValid = 1'b1; reqAddr = a; reqData = d;
    @(negedge clk);
    reqValid = 1'b0;
    check(!reqReady, "R2 ready low when busy", reqReady, 0);
    check(tries == 1, "R9 tries restart", tries, 1);
    if (junk) begin
      reqValid = 1'b1; reqAddr = ~a; reqData = ~d;
      repeat (4) @(negedge clk);
      reqValid = 1'b0;
    end
    while (!doneOk && !doneFail && cyc < 500) begin
      check(!reqReady, "R2 ready low until done", reqReady, 0);
      @(negedge clk); cyc++;
    end
    check(doneOk == expOk, expOk ? "R6 success" : "R8 failure", doneOk, expOk);
    check(doneFail == !expOk, "R8 fail pulse", doneFail, !expOk);
    check(tries == expTries, expOk ? "R6 tries" : "R8 tries", tries, expTries);
    check(armWrites - arm0 == expTries, "R7 attempts restarted", armWrites - arm0, expTries);
    check(reqReady, "R2 ready at done", reqReady, 1);
    @(negedge clk);
    check(!doneOk && !doneFail, "R6 single pulse", doneOk | doneFail, 0);
    begin
      int bc = busCount;
      repeat (3) @(negedge clk);
      check(busCount == bc, "R8 bus quiet after done", busCount - bc, 0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1
    check(reqReady, "R1 ready", reqReady, 1);
    check(!busWr && !busRd, "R1 bus idle", busWr | busRd, 0);
    check(!doneOk && !doneFail, "R1 done low", doneOk | doneFail, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(reqReady && !busWr && !busRd, "R1 after release", reqReady, 1);
    doReq(16'h1234, 8'hA5, 0, 1'b0);
    doReq(16'hFFFF, 8'h40, 2, 1'b1);   // R2 junk offers while busy
    doReq(16'h0000, 8'hC0, MAXT - 1, 1'b0);
    doReq(16'h8001, 8'h00, MAXT, 1'b0);   // R8 limit
    doReq(16'h0042, 8'hFF, 0, 1'b0);      // R9 after fail
    void'($urandom(32'd4711));
    for (int i = 0; i < 20; i++)
      doReq(ADDR_W'($urandom), 8'($urandom), int'($urandom % (MAXT + 2)), ($urandom % 4) == 0);
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule